// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight level-sensed interrupt lines and raises one interrupt request toward a processor. Software reaches it through a byte-wide port with two addresses. Address 0 is the command port and address 1 is the data port. It keeps three 8-bit registers: pending requests, levels in service and a line mask. Line 0 has the highest fixed priority. A request interrupts only when it is unmasked and outranks every level already in service.

Software first writes an initialization sequence. After that it uses single-byte commands to retire a specific level and to choose which register the command port returns on reads. On a one-cycle acknowledge, the controller drives a vector equal to a programmed base plus the winning line number, and it marks that line as in service. An optional automatic mode skips the in-service mark, so no end-of-interrupt command is needed. The cascade byte and the master/slave role are stored and presented on outputs for the surrounding logic.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `int_req` is low, the mask and in-service registers are zero, the vector base is zero, and command-port reads return the request register.
- R2: A command-port write of 0x11 begins initialization. In the same step it clears the mask and in-service registers and selects the request register for reads. The next three data-port writes load, in this order: the vector base, the cascade byte (`casc_cfg`), and the mode byte. In the mode byte, bit 1 enables automatic mode and bit 2 selects the slave role (`casc_slave`). None of these three writes changes the mask.
- R3: Outside initialization, a data-port write loads the mask register, and a data-port read returns it. A set mask bit stops that line from raising `int_req`.
- R4: `int_req` is high exactly when some unmasked pending line has a lower index than every in-service level. Line 0 ranks highest.
- R5: While `int_req` is high, `ack` drives `vec` = base + winning line number in that cycle. In normal mode it sets that line's in-service bit at the next edge.
- R6: In automatic mode, an acknowledge leaves the in-service register unchanged.
- R7: A command-port write of 0x60+n (n = 0 to 7) clears in-service bit n and no other bit.
- R8: A command-port write of 0x0A selects the request register and 0x0B selects the in-service register for later command-port reads. The selection holds until it is changed.
- R9: An `ack` while `int_req` is low is spurious. It drives `vec` = base + 7, even when line 7 is masked, and sets no in-service bit.
- R10: A specific end-of-interrupt and an acknowledge in the same cycle both take effect.
- R11: `irq_in` is registered into the request register, so `int_req` responds one cycle after a line changes.
- R12: A command-port byte other than 0x11, 0x0A, 0x0B or 0x60 to 0x67 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `addr` |
| irq_in | input | 8 | Level-sensed interrupt lines |
| int_req | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge |
| vec | output | 8 | Vector while `ack` is high, else zero |
| casc_cfg | output | 8 | Programmed cascade byte |
| casc_slave | output | 1 | Programmed slave role |

## Verification
Retiring one level and granting another can fall in the same cycle, because the in-service register has both a set path and a clear path. The bench provokes this with level 3 in service and line 1 pending. It writes the end-of-interrupt for level 3 in the same cycle as `ack`. It then expects vector base+1 and an in-service readback of exactly 0x02. A behavioural model, updated on every edge, is compared against every output on every cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_state_e;

  localparam logic [7:0] CMD_INIT    = 8'h11;
  localparam logic [7:0] CMD_RD_REQ  = 8'h0A;
  localparam logic [7:0] CMD_RD_SRV  = 8'h0B;
  localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
  localparam int unsigned MODE_AUTO_BIT  = 1;
  localparam int unsigned MODE_SLAVE_BIT = 2;
endpackage

// File: rtl/prio_irq_cmd.sv
module prio_irq_cmd
  import prio_irq_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    imr,
  output logic [DW-1:0]    base,
  output logic [DW-1:0]    casc_cfg,
  output logic             casc_slave,
  output logic             aeoi,
  output logic             sel_isr,
  output logic             init_start,
  output logic             eoi_valid,
  output logic [IDX_W-1:0] eoi_lvl
);
  init_state_e st_q, st_d;
  logic [DW-1:0] imr_d, base_d, casc_d;
  logic          slave_d, aeoi_d, sel_d;
  logic          cmd_wr, dat_wr;

  assign cmd_wr     = wr_en && !addr;
  assign dat_wr     = wr_en && addr;
  assign init_start = cmd_wr && (wr_data == CMD_INIT);
  assign eoi_valid  = cmd_wr && (st_q == ST_RUN) && (wr_data[7:3] == CMD_EOI_TOP);
  assign eoi_lvl    = wr_data[IDX_W-1:0];

  always_comb begin
    st_d    = st_q;
    imr_d   = imr;
    base_d  = base;
    casc_d  = casc_cfg;
    slave_d = casc_slave;
    aeoi_d  = aeoi;
    sel_d   = sel_isr;
    if (init_start) begin
      st_d  = ST_BASE;
      imr_d = '0;
      sel_d = 1'b0;
    end else if (cmd_wr && st_q == ST_RUN) begin
      if (wr_data == CMD_RD_REQ) sel_d = 1'b0;
      else if (wr_data == CMD_RD_SRV) sel_d = 1'b1;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_RUN:  imr_d = wr_data;
        ST_BASE: begin base_d = wr_data; st_d = ST_CASC; end
        ST_CASC: begin casc_d = wr_data; st_d = ST_MODE; end
        ST_MODE: begin
          aeoi_d  = wr_data[MODE_AUTO_BIT];
          slave_d = wr_data[MODE_SLAVE_BIT];
          st_d    = ST_RUN;
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      imr        <= '0;
      base       <= '0;
      casc_cfg   <= '0;
      casc_slave <= 1'b0;
      aeoi       <= 1'b0;
      sel_isr    <= 1'b0;
    end else begin
      st_q       <= st_d;
      imr        <= imr_d;
      base       <= base_d;
      casc_cfg   <= casc_d;
      casc_slave <= slave_d;
      aeoi       <= aeoi_d;
      sel_isr    <= sel_d;
    end
  end

  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (imr == '0 && !sel_isr)); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && st_q == ST_RUN) |=> (imr == $past(wr_data))); // R3
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned LINES = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] imr,
  input  logic [LINES-1:0] isr,
  output logic             int_req,
  output logic [IDX_W-1:0] win_idx
);
  logic [LINES-1:0] busy_upto;
  logic [LINES-1:0] eligible;

  assign busy_upto[0] = isr[0];
  genvar g;
  generate
    for (g = 1; g < LINES; g++) begin : g_busy
      assign busy_upto[g] = busy_upto[g-1] | isr[g];
    end
  endgenerate

  assign eligible = irr & ~imr & ~busy_upto;
  assign int_req  = |eligible;

  always_comb begin
    win_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eligible[i]) win_idx = IDX_W'(i);
    end
  end

  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr[win_idx] && !imr[win_idx])); // R4

  AST_WIN_OUTRANKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((isr & ((LINES'(1) << (win_idx + 1'b1)) - 1'b1)) == '0)); // R4
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [LINES-1:0] irq_in,
  output logic             int_req,
  input  logic             ack,
  output logic [7:0]       vec,
  output logic [7:0]       casc_cfg,
  output logic             casc_slave
);
  localparam int unsigned DW    = 8;
  localparam int unsigned IDX_W = $clog2(LINES);

  logic             rst_s1, rst_sync_n;
  logic [LINES-1:0] irr_q, isr_q, isr_d;
  logic [DW-1:0]    imr, base;
  logic             aeoi, sel_isr, init_start, eoi_valid;
  logic [IDX_W-1:0] eoi_lvl, win_idx;
  logic             grant;
  logic [LINES-1:0] set_mask, clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  prio_irq_cmd #(.DW(DW), .IDX_W(IDX_W)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .imr(imr), .base(base), .casc_cfg(casc_cfg), .casc_slave(casc_slave),
    .aeoi(aeoi), .sel_isr(sel_isr), .init_start(init_start),
    .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl)
  );

  prio_irq_arb #(.LINES(LINES), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .irr(irr_q), .imr(imr[LINES-1:0]), .isr(isr_q),
    .int_req(int_req), .win_idx(win_idx)
  );

  assign grant    = ack && int_req;
  assign set_mask = (grant && !aeoi) ? (LINES'(1) << win_idx) : '0;
  assign clr_mask = eoi_valid ? (LINES'(1) << eoi_lvl) : '0;

  always_comb begin
    if (init_start) isr_d = '0;
    else            isr_d = (isr_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irq_in;
      isr_q <= isr_d;
    end
  end

  always_comb begin
    if (!ack)         vec = '0;
    else if (int_req) vec = base + DW'(win_idx);
    else              vec = base + DW'(LINES - 1);
  end

  always_comb begin
    if (addr)         rd_data = imr;
    else if (sel_isr) rd_data = DW'(isr_q);
    else              rd_data = DW'(irr_q);
  end

  AST_GRANT_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grant && !aeoi && !init_start) |=> isr_q[$past(win_idx)]); // R5

  AST_AUTO_NO_MARK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    aeoi |=> ((isr_q & ~$past(isr_q)) == '0)); // R6

  AST_SPURIOUS_NO_MARK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack && !int_req) |=> ((isr_q & ~$past(isr_q)) == '0)); // R9

  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eoi_valid && !(grant && win_idx == eoi_lvl)) |=> !isr_q[$past(eoi_lvl)]); // R7
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_wr = 1'b0, b_addr = 1'b0, b_ack = 1'b0;
  logic [7:0] b_data = 8'h00, b_irq = 8'h00;
  logic [7:0] rd_data, vec, casc_cfg;
  logic       int_req, casc_slave;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .addr(b_addr), .wr_data(b_data),
    .rd_data(rd_data), .irq_in(b_irq), .int_req(int_req), .ack(b_ack), .vec(vec),
    .casc_cfg(casc_cfg), .casc_slave(casc_slave)
  );

  // behavioural reference state
  logic [7:0] m_irr, m_isr, m_imr, m_base, m_casc;
  logic       m_slave, m_aeoi, m_sel;
  int         m_phase; // 0 running, 1..3 = next init data word

  function automatic int first_set(input logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic exp_int();
    return first_set(m_irr & ~m_imr) < first_set(m_isr);
  endfunction

  function automatic logic [7:0] exp_vec();
    if (!b_ack) return 8'h00;
    if (exp_int()) return m_base + 8'(first_set(m_irr & ~m_imr));
    return m_base + 8'd7;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (b_addr) return m_imr;
    return m_sel ? m_isr : m_irr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_base = 0; m_casc = 0;
      m_slave = 0; m_aeoi = 0; m_sel = 0; m_phase = 0;
    end else begin
      logic granted;
      int   win;
      granted = b_ack && exp_int();
      win     = first_set(m_irr & ~m_imr);
      if (b_wr && !b_addr && b_data == 8'h11) begin
        m_isr = 0; m_imr = 0; m_sel = 0; m_phase = 1;
      end else begin
        if (b_wr && !b_addr && m_phase == 0) begin
          if (b_data == 8'h0A) m_sel = 0;
          else if (b_data == 8'h0B) m_sel = 1;
          else if (b_data >= 8'h60 && b_data <= 8'h67) m_isr[b_data - 8'h60] = 1'b0;
        end else if (b_wr && b_addr) begin
          case (m_phase)
            0: m_imr = b_data;
            1: begin m_base = b_data; m_phase = 2; end
            2: begin m_casc = b_data; m_phase = 3; end
            default: begin m_aeoi = b_data[1]; m_slave = b_data[2]; m_phase = 0; end
          endcase
        end
        if (granted && !m_aeoi) m_isr[win] = 1'b1;
      end
      m_irr = b_irq;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of stimulus, then compare every output with the model
  task automatic step(input logic w, input logic a, input logic [7:0] d,
                      input logic k, input logic [7:0] irq, input string tag);
    @(negedge clk);
    b_wr = w; b_addr = a; b_data = d; b_ack = k; b_irq = irq;
    #1;
    check({tag, " model int_req"}, {7'd0, int_req}, {7'd0, exp_int()});
    check({tag, " model vec"}, vec, exp_vec());
    check({tag, " model rd_data"}, rd_data, exp_rd());
    check({tag, " model casc"}, {casc_slave, casc_cfg[6:0]}, {m_slave, m_casc[6:0]});
  endtask

  task automatic cmd(input logic [7:0] d, input logic [7:0] irq, input string tag);
    step(1'b1, 1'b0, d, 1'b0, irq, tag);
  endtask
  task automatic dat(input logic [7:0] d, input logic [7:0] irq, input string tag);
    step(1'b1, 1'b1, d, 1'b0, irq, tag);
  endtask
  task automatic idle(input logic a, input logic [7:0] irq, input string tag);
    step(1'b0, a, 8'h00, 1'b0, irq, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle(1'b0, 8'h00, "R1 settle");
    idle(1'b0, 8'h00, "R1");
    check("R1 int_req low", {7'd0, int_req}, 8'h00);
    check("R1 request readback", rd_data, 8'h00);
    idle(1'b1, 8'h00, "R1");
    check("R1 mask zero", rd_data, 8'h00);

    // R2 initialization: base 0x20, cascade 0x04, normal mode master
    cmd(8'h11, 8'h00, "R2");
    dat(8'h20, 8'h00, "R2");
    dat(8'h04, 8'h00, "R2");
    dat(8'h01, 8'h00, "R2");
    idle(1'b1, 8'h00, "R2");
    check("R2 cascade byte", casc_cfg, 8'h04);
    check("R2 master role", {7'd0, casc_slave}, 8'h00);
    check("R2 init words leave mask", rd_data, 8'h00);

    // R11 one-cycle registration of line 3
    idle(1'b0, 8'h08, "R11");
    check("R11 not yet raised", {7'd0, int_req}, 8'h00);
    idle(1'b0, 8'h08, "R11");
    check("R11 raised next cycle", {7'd0, int_req}, 8'h01);
    check("R11 request readback", rd_data, 8'h08);

    step(1'b0, 1'b0, 8'h00, 1'b1, 8'h08, "R5");
    check("R5 vector base+3", vec, 8'h23);
    cmd(8'h0B, 8'h08, "R8");
    idle(1'b0, 8'h08, "R8");
    check("R5 R8 service readback", rd_data, 8'h08);
    check("R4 own level blocked", {7'd0, int_req}, 8'h00);

    idle(1'b0, 8'h28, "R4");
    idle(1'b0, 8'h28, "R4");
    check("R4 lower line blocked", {7'd0, int_req}, 8'h00);
    idle(1'b0, 8'h2A, "R4");
    idle(1'b0, 8'h2A, "R4");
    check("R4 higher line raises", {7'd0, int_req}, 8'h01);

    // R10 end-of-interrupt for 3 with acknowledge of 1 in one cycle
    step(1'b1, 1'b0, 8'h63, 1'b1, 8'h2A, "R10");
    check("R10 vector base+1", vec, 8'h21);
    idle(1'b0, 8'h2A, "R10");
    check("R10 service is line 1 only", rd_data, 8'h02);

    dat(8'h02, 8'h2A, "R3");
    cmd(8'h61, 8'h2A, "R7");
    idle(1'b0, 8'h2A, "R7");
    check("R7 service cleared", rd_data, 8'h00);
    check("R3 masked line 1 skipped, line 3 wins", {7'd0, int_req}, 8'h01);
    idle(1'b1, 8'h2A, "R3");
    check("R3 mask readback", rd_data, 8'h02);
    step(1'b0, 1'b0, 8'h00, 1'b1, 8'h2A, "R3");
    check("R3 vector base+3", vec, 8'h23);

    cmd(8'h55, 8'h2A, "R12");
    idle(1'b0, 8'h2A, "R12");
    check("R12 service and select kept", rd_data, 8'h08);
    cmd(8'h0A, 8'h2A, "R8");
    idle(1'b0, 8'h2A, "R8");
    check("R8 request select", rd_data, 8'h2A);
    idle(1'b0, 8'h2A, "R8");
    check("R8 select persists", rd_data, 8'h2A);

    cmd(8'h63, 8'h2A, "R7");
    dat(8'hFF, 8'h2A, "R3");
    idle(1'b0, 8'h2A, "R3");
    check("R3 all masked", {7'd0, int_req}, 8'h00);
    step(1'b0, 1'b0, 8'h00, 1'b1, 8'h2A, "R9");
    check("R9 spurious vector", vec, 8'h27);
    cmd(8'h0B, 8'h2A, "R9");
    idle(1'b0, 8'h2A, "R9");
    check("R9 no service bit", rd_data, 8'h00);

    // put line 1 in service, then re-initialize into automatic slave mode
    dat(8'h00, 8'h2A, "R2");
    step(1'b0, 1'b0, 8'h00, 1'b1, 8'h2A, "R2");
    idle(1'b0, 8'h2A, "R2");
    check("R2 pre-init service", rd_data, 8'h02);
    cmd(8'h11, 8'h40, "R2");
    dat(8'h40, 8'h40, "R2");
    dat(8'h02, 8'h40, "R2");
    dat(8'h06, 8'h40, "R2");
    idle(1'b0, 8'h40, "R2");
    check("R2 select back to request", rd_data, 8'h40);
    check("R2 slave role", {7'd0, casc_slave}, 8'h01);
    check("R2 cascade id", casc_cfg, 8'h02);
    idle(1'b1, 8'h40, "R2");
    check("R2 mask cleared", rd_data, 8'h00);
    cmd(8'h0B, 8'h40, "R2");
    idle(1'b0, 8'h40, "R2");
    check("R2 service cleared", rd_data, 8'h00);

    step(1'b0, 1'b0, 8'h00, 1'b1, 8'h40, "R6");
    check("R6 vector base+6", vec, 8'h46);
    idle(1'b0, 8'h40, "R6");
    check("R6 no service bit", rd_data, 8'h00);
    check("R6 still requesting", {7'd0, int_req}, 8'h01);
    idle(1'b0, 8'h00, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule